// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It drives the command bus from reset until the device is ready: clock enable, chip select, the three strobes, bank address and row address. After reset it holds the bus quiet with clock enable low for a stable-power interval. It then raises clock enable and waits a short settle interval. From there it walks a fixed bring-up order: precharge-all, the extended register writes, DLL reset, a second precharge-all, a train of auto-refreshes, the operating mode write, and then two writes that enter and leave the off-chip driver default setting. When the sequence ends it raises a done flag.

Every wait is a parameter counted in clock cycles: stable-power hold, settle interval, mode-write recovery, precharge recovery, refresh cycle time and DLL lock time. The refresh count is also a parameter, at least 2. The contents of the mode register and of extended registers 1 and 2 come from three configuration inputs. The sequencer forces only the bits the bring-up itself must own. The row address must be at least 12 bits wide.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low, and for T_PWR cycles after its release, cke_o is 0, done_o is 0 and the bus carries NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R2: cke_o goes to 1 on the T_PWR-th rising edge after reset release. The first command is precharge-all, issued T_400 cycles later.
- R3: Commands are issued in this order: precharge-all, EMR2 write, EMR3 write, EMR1 write, MR write with DLL reset, precharge-all, N_REF refreshes, MR write, EMR1 write with driver default, EMR1 write with driver exit. Pin codes {cs_n,ras_n,cas_n,we_n} are 0010 for precharge, 0000 for a register write and 0001 for refresh. The bank selects the register: 000 MR, 001 EMR1, 010 EMR2, 011 EMR3.
- R4: The next command follows T_MRD cycles after a register write and T_RP cycles after a precharge-all. It follows T_RFC cycles after each refresh, including the last one before the MR write.
- R5: The driver-default EMR1 write comes at the later of two points: T_MRD cycles after the operating MR write, or T_DLL cycles after the DLL-reset MR write.
- R6: Once cke_o is 1 it stays 1. Every cycle that does not carry one of the commands of R3 carries NOP.
- R7: Both MR writes take A12:A9 and A6:A0 from mr_cfg_i, with A7=0 and A13=0. A8 is 1 in the first write and 0 in the second.
- R8: All three EMR1 writes take A12:A10 and A6:A1 from emr1_cfg_i, with A0=0 (DLL on) and A13=0. A9:A7 is 000 in the first write, 111 (driver default) in the second and 000 (driver exit) in the third.
- R9: The EMR2 write carries {0, emr2_cfg_i}. The EMR3 write carries all zeros. Both precharge-all commands carry only A10=1 with bank 000.
- R10: done_o rises T_MRD cycles after the driver-exit write and then stays 1 with the bus held at NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mr_cfg_i | input | ROW_W-1 | Operating mode register contents (A12:A0) |
| emr1_cfg_i | input | ROW_W-1 | Extended register 1 contents (A12:A0) |
| emr2_cfg_i | input | ROW_W-1 | Extended register 2 contents (A12:A0) |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address / register select |
| addr_o | output | ROW_W | Address bus |
| done_o | output | 1 | Sequence complete |

## Verification
Two timers can release the driver-default write in the same cycle. One is the mode-write recovery that follows the operating MR write. The other is the DLL lock count that started at the DLL-reset write. One bench instance sizes its refresh, precharge and mode-write times so that both timers expire on the same edge; the write must then appear exactly on that edge, not one cycle later. A second instance uses a long lock time, so the lock count alone decides the cycle. In both instances the expected cycle is the later of the two points, computed by the bench.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [1:0] {CMD_NOP, CMD_PREA, CMD_MRS, CMD_REF} cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_PREA0, ST_EMR2, ST_EMR3, ST_EMR1, ST_MR_DLL, ST_PREA1,
    ST_REF, ST_MR_OP, ST_OCD_DEF, ST_OCD_EXIT, ST_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam logic [2:0] OCD_DEFAULT = 3'b111;
  localparam logic [2:0] OCD_LEAVE   = 3'b000;

  function automatic pins_t encode(cmd_e c);
    pins_t p;
    unique case (c)
      CMD_PREA: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      CMD_MRS:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      CMD_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      default:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ddr2_init_timer.sv
module ddr2_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ddr2_init_dll_wait.sv
module ddr2_init_dll_wait #(
  parameter int T_DLL = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ok_o
);
  localparam int W = $clog2(T_DLL + 1);

  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= W'(1);
      run_q <= 1'b1;
    end else if (run_q && cnt_q != W'(T_DLL)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ok_o = run_q && (cnt_q == W'(T_DLL));
endmodule

// File: rtl/ddr2_init_fsm.sv
module ddr2_init_fsm
  import ddr2_init_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3,
  parameter int CNT_W = 8,
  parameter int T_400 = 134,
  parameter int T_MRD = 2,
  parameter int T_RP  = 5,
  parameter int T_RFC = 65,
  parameter int N_REF = 2,
  localparam int CFG_W = ROW_W - 1,
  localparam int REF_W = $clog2(N_REF + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             dll_ok_i,
  input  logic [CFG_W-1:0] mr_cfg_i,
  input  logic [CFG_W-1:0] emr1_cfg_i,
  input  logic [CFG_W-1:0] emr2_cfg_i,
  output logic             load_o,
  output logic [CNT_W-1:0] val_o,
  output logic             dll_start_o,
  output logic             cke_o,
  output pins_t            pins_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             done_o
);
  step_e            step_q, step_d;
  logic [REF_W-1:0] ref_q, ref_d;
  cmd_e             cmd;
  logic             go;

  logic unused_cfg;
  assign unused_cfg = ^{mr_cfg_i[8:7], emr1_cfg_i[9:7], emr1_cfg_i[0]};

  function automatic logic [ROW_W-1:0] mr_word(logic dll_rst);
    return {1'b0, mr_cfg_i[CFG_W-1:9], dll_rst, 1'b0, mr_cfg_i[6:0]};
  endfunction

  function automatic logic [ROW_W-1:0] emr1_word(logic [2:0] ocd);
    return {1'b0, emr1_cfg_i[CFG_W-1:10], ocd, emr1_cfg_i[6:1], 1'b0};
  endfunction

  // driver-default write is also gated by DLL lock
  assign go = zero_i && (step_q != ST_OCD_DEF || dll_ok_i);

  always_comb begin
    step_d      = step_q;
    ref_d       = ref_q;
    cmd         = CMD_NOP;
    ba_o        = '0;
    addr_o      = '0;
    load_o      = 1'b0;
    val_o       = '0;
    dll_start_o = 1'b0;
    done_o      = 1'b0;
    if (go) begin
      load_o = 1'b1;
      val_o  = CNT_W'(T_MRD - 1);
      unique case (step_q)
        ST_PWR: begin
          val_o  = CNT_W'(T_400 - 1);
          step_d = ST_PREA0;
        end
        ST_PREA0, ST_PREA1: begin
          cmd        = CMD_PREA;
          addr_o[10] = 1'b1;
          val_o      = CNT_W'(T_RP - 1);
          step_d     = (step_q == ST_PREA0) ? ST_EMR2 : ST_REF;
        end
        ST_EMR2: begin
          cmd    = CMD_MRS;
          ba_o   = BA_W'(2);
          addr_o = {1'b0, emr2_cfg_i};
          step_d = ST_EMR3;
        end
        ST_EMR3: begin
          cmd    = CMD_MRS;
          ba_o   = BA_W'(3);
          step_d = ST_EMR1;
        end
        ST_EMR1: begin
          cmd    = CMD_MRS;
          ba_o   = BA_W'(1);
          addr_o = emr1_word(OCD_LEAVE);
          step_d = ST_MR_DLL;
        end
        ST_MR_DLL: begin
          cmd         = CMD_MRS;
          addr_o      = mr_word(1'b1);
          dll_start_o = 1'b1;
          step_d      = ST_PREA1;
        end
        ST_REF: begin
          cmd   = CMD_REF;
          val_o = CNT_W'(T_RFC - 1);
          ref_d = ref_q + 1'b1;
          if (ref_q == REF_W'(N_REF - 1)) step_d = ST_MR_OP;
        end
        ST_MR_OP: begin
          cmd    = CMD_MRS;
          addr_o = mr_word(1'b0);
          step_d = ST_OCD_DEF;
        end
        ST_OCD_DEF: begin
          cmd    = CMD_MRS;
          ba_o   = BA_W'(1);
          addr_o = emr1_word(OCD_DEFAULT);
          step_d = ST_OCD_EXIT;
        end
        ST_OCD_EXIT: begin
          cmd    = CMD_MRS;
          ba_o   = BA_W'(1);
          addr_o = emr1_word(OCD_LEAVE);
          step_d = ST_DONE;
        end
        default: begin
          load_o = 1'b0;
          done_o = 1'b1;
        end
      endcase
    end
  end

  assign pins_o = encode(cmd);
  assign cke_o  = (step_d != ST_PWR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_PWR;
      ref_q  <= '0;
    end else begin
      step_q <= step_d;
      ref_q  <= ref_d;
    end
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3,
  parameter int T_PWR = 66700,
  parameter int T_400 = 134,
  parameter int T_MRD = 2,
  parameter int T_RP  = 5,
  parameter int T_RFC = 65,
  parameter int T_DLL = 200,
  parameter int N_REF = 2,
  localparam int CFG_W = ROW_W - 1,
  localparam int CNT_W = $clog2(T_PWR + T_400 + T_MRD + T_RP + T_RFC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] mr_cfg_i,
  input  logic [CFG_W-1:0] emr1_cfg_i,
  input  logic [CFG_W-1:0] emr2_cfg_i,
  output logic             cke_o,
  output logic             cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             done_o
);
  logic             zero, dll_ok, load, dll_start, cke_d, done_d;
  logic [CNT_W-1:0] val;
  pins_t            pins_d, pins_q;
  logic [BA_W-1:0]  ba_d;
  logic [ROW_W-1:0] addr_d;

  ddr2_init_timer #(.CNT_W(CNT_W), .RST_VAL(T_PWR - 1)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .val_i(val), .zero_o(zero)
  );

  ddr2_init_dll_wait #(.T_DLL(T_DLL)) i_dll_wait (
    .clk_i, .rst_ni, .start_i(dll_start), .ok_o(dll_ok)
  );

  ddr2_init_fsm #(
    .ROW_W(ROW_W), .BA_W(BA_W), .CNT_W(CNT_W), .T_400(T_400), .T_MRD(T_MRD),
    .T_RP(T_RP), .T_RFC(T_RFC), .N_REF(N_REF)
  ) i_fsm (
    .clk_i, .rst_ni, .zero_i(zero), .dll_ok_i(dll_ok),
    .mr_cfg_i, .emr1_cfg_i, .emr2_cfg_i,
    .load_o(load), .val_o(val), .dll_start_o(dll_start), .cke_o(cke_d),
    .pins_o(pins_d), .ba_o(ba_d), .addr_o(addr_d), .done_o(done_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o  <= 1'b0;
      pins_q <= encode(CMD_NOP);
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      cke_o  <= cke_d;
      pins_q <= pins_d;
      ba_o   <= ba_d;
      addr_o <= addr_d;
      done_o <= done_d;
    end
  end

  assign cs_n_o  = pins_q.cs_n;
  assign ras_n_o = pins_q.ras_n;
  assign cas_n_o = pins_q.cas_n;
  assign we_n_o  = pins_q.we_n;
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ROW_W = 14,
  parameter int BA_W  = 3,
  parameter int T_MRD = 2,
  parameter int T_DLL = 200
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cke_o,
  input logic             cs_n_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [BA_W-1:0]  ba_o,
  input logic [ROW_W-1:0] addr_o,
  input logic             done_o
);
  logic nop, mrs, dll_rst, ocd_def;
  int   dll_cnt_q;
  logic dll_seen_q;

  assign nop     = !cs_n_o && ras_n_o && cas_n_o && we_n_o;
  assign mrs     = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;
  assign dll_rst = mrs && ba_o == '0 && addr_o[8];
  assign ocd_def = mrs && ba_o == BA_W'(1) && addr_o[9:7] == 3'b111;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dll_cnt_q  <= 0;
      dll_seen_q <= 1'b0;
    end else if (dll_rst) begin
      dll_cnt_q  <= 1;
      dll_seen_q <= 1'b1;
    end else if (dll_seen_q && dll_cnt_q < T_DLL) begin
      dll_cnt_q <= dll_cnt_q + 1;
    end
  end

  p_cke_low_nop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> nop && !done_o);
  p_cke_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_o |=> cke_o);
  p_reg_bank_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs |-> ba_o < BA_W'(4));
  p_a13_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs && ba_o < BA_W'(2) |-> !addr_o[ROW_W-1]);
  p_dll_on_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs && ba_o == BA_W'(1) |-> !addr_o[0]);
  p_mrd_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrs && T_MRD > 1 |=> nop);
  p_dll_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocd_def |-> dll_seen_q && dll_cnt_q >= T_DLL);
  p_done_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_done_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> nop);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
  .ROW_W(ROW_W), .BA_W(BA_W), .T_MRD(T_MRD), .T_DLL(T_DLL)
) i_ddr2_init_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_o(cke_o), .cs_n_o(cs_n_o),
  .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o), .ba_o(ba_o),
  .addr_o(addr_o), .done_o(done_o)
);

// File: tb/test_ddr2_init_seq.sv
module test_ddr2_init_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NK = 2;
  localparam int MAXEV = 32;
  // instance 0: MRD expiry and DLL lock land on the same edge; instance 1: lock dominates
  localparam int P_PWR [NK] = '{10, 7};
  localparam int P_400 [NK] = '{4, 3};
  localparam int P_MRD [NK] = '{2, 3};
  localparam int P_RP  [NK] = '{3, 2};
  localparam int P_RFC [NK] = '{5, 4};
  localparam int P_REF [NK] = '{3, 2};
  localparam int P_DLL [NK] = '{22, 60};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [12:0] mr_cfg, emr1_cfg, emr2_cfg;
  logic        cke_w  [NK];
  logic        cs_w   [NK];
  logic        ras_w  [NK];
  logic        cas_w  [NK];
  logic        we_w   [NK];
  logic [2:0]  ba_w   [NK];
  logic [13:0] addr_w [NK];
  logic        done_w [NK];

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ev_n [NK];
  int ev_cyc [NK][MAXEV];
  logic [20:0] ev_val [NK][MAXEV];
  int cke_rise [NK];
  int done_cyc [NK];
  bit done_seen [NK];
  int err_r1 [NK];
  int err_r10 [NK];

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NK; g++) begin : g_dut
    ddr2_init_seq #(
      .T_PWR(P_PWR[g]), .T_400(P_400[g]), .T_MRD(P_MRD[g]), .T_RP(P_RP[g]),
      .T_RFC(P_RFC[g]), .T_DLL(P_DLL[g]), .N_REF(P_REF[g])
    ) i_ddr2_init_seq (
      .clk_i(clk), .rst_ni(rst_n), .mr_cfg_i(mr_cfg), .emr1_cfg_i(emr1_cfg),
      .emr2_cfg_i(emr2_cfg), .cke_o(cke_w[g]), .cs_n_o(cs_w[g]), .ras_n_o(ras_w[g]),
      .cas_n_o(cas_w[g]), .we_n_o(we_w[g]), .ba_o(ba_w[g]), .addr_o(addr_w[g]),
      .done_o(done_w[g])
    );
  end

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NK; k++) begin
        logic nop;
        nop = !cs_w[k] && ras_w[k] && cas_w[k] && we_w[k];
        if (!cke_w[k]) begin
          if (cke_rise[k] >= 0 || !nop || done_w[k] || cyc >= P_PWR[k]) err_r1[k]++;
        end else begin
          if (cke_rise[k] < 0) cke_rise[k] = cyc;
          if (!nop) begin
            if (ev_n[k] < MAXEV) begin
              ev_cyc[k][ev_n[k]] = cyc;
              ev_val[k][ev_n[k]] = {cs_w[k], ras_w[k], cas_w[k], we_w[k], ba_w[k], addr_w[k]};
            end
            ev_n[k]++;
          end
        end
        if (done_w[k] && !done_seen[k]) begin
          done_seen[k] = 1'b1;
          done_cyc[k] = cyc;
        end
        if (done_seen[k] && (!done_w[k] || !nop)) err_r10[k]++;
      end
    end
  end

  function automatic logic [13:0] mr_w(logic dll);
    return {1'b0, mr_cfg[12:9], dll, 1'b0, mr_cfg[6:0]};
  endfunction

  function automatic logic [13:0] emr1_w(logic [2:0] ocd);
    return {1'b0, emr1_cfg[12:10], ocd, emr1_cfg[6:1], 1'b0};
  endfunction

  // expected {cs_n,ras_n,cas_n,we_n, ba, addr} of the i-th command
  function automatic logic [20:0] exp_word(int i, int nref);
    logic [3:0] p = 4'b0000;
    logic [2:0] b = 3'd0;
    logic [13:0] a = '0;
    if (i == 0 || i == 5) begin p = 4'b0010; a[10] = 1'b1; end
    else if (i == 1) begin b = 3'd2; a = {1'b0, emr2_cfg}; end
    else if (i == 2) b = 3'd3;
    else if (i == 3) begin b = 3'd1; a = emr1_w(3'b000); end
    else if (i == 4) a = mr_w(1'b1);
    else if (i < 6 + nref) p = 4'b0001;
    else if (i == 6 + nref) a = mr_w(1'b0);
    else if (i == 7 + nref) begin b = 3'd1; a = emr1_w(3'b111); end
    else begin b = 3'd1; a = emr1_w(3'b000); end
    return {p, b, a};
  endfunction

  function automatic string val_tag(int i, int nref);
    if (i <= 2 || i == 5) return "R9";
    if (i == 4 || i == 6 + nref) return "R7";
    if (i == 3 || i >= 7 + nref) return "R8";
    return "R3";
  endfunction

  task automatic evaluate(int k);
    int nref = P_REF[k];
    int ne = 9 + nref;
    int t = P_PWR[k] + P_400[k];
    int t_dll = 0;
    chk(err_r1[k] == 0, "R1", "cke low with non-NOP or too long", err_r1[k], 0);
    chk(cke_rise[k] == P_PWR[k], "R2", "cke rise cycle", cke_rise[k], P_PWR[k]);
    chk(ev_n[k] == ne, "R6", "command count", ev_n[k], ne);
    for (int i = 0; i < ne; i++) begin
      if (i > 0) begin
        if (i == 1 || i == 6) t += P_RP[k];
        else if (i <= 5 || i == 8 + nref) t += P_MRD[k];
        else if (i <= 6 + nref) t += P_RFC[k];
        else t = (t + P_MRD[k] > t_dll + P_DLL[k]) ? t + P_MRD[k] : t_dll + P_DLL[k];
      end
      if (i == 4) t_dll = t;
      if (i < ev_n[k] && i < MAXEV) begin
        chk(ev_cyc[k][i] == t, (i == 0) ? "R2" : (i == 7 + nref) ? "R5" : "R4",
            $sformatf("inst %0d cmd %0d cycle", k, i), ev_cyc[k][i], t);
        chk(ev_val[k][i] == exp_word(i, nref), val_tag(i, nref),
            $sformatf("inst %0d cmd %0d word", k, i), int'(ev_val[k][i]),
            int'(exp_word(i, nref)));
      end else begin
        chk(1'b0, "R3", $sformatf("inst %0d cmd %0d missing", k, i), ev_n[k], ne);
      end
    end
    chk(done_seen[k] && done_cyc[k] == t + P_MRD[k], "R10", "done cycle",
        done_cyc[k], t + P_MRD[k]);
    chk(err_r10[k] == 0, "R10", "done held with NOP", err_r10[k], 0);
  endtask

  initial begin
    void'($urandom(32'd1337));
    for (int r = 0; r < 5; r++) begin
      if (r == 0) begin mr_cfg = '1; emr1_cfg = '1; emr2_cfg = '1; end
      else if (r == 1) begin mr_cfg = '0; emr1_cfg = '0; emr2_cfg = '0; end
      else begin
        mr_cfg = 13'($urandom); emr1_cfg = 13'($urandom); emr2_cfg = 13'($urandom);
      end
      rst_n = 1'b0;
      for (int k = 0; k < NK; k++) begin
        ev_n[k] = 0; cke_rise[k] = -1; done_cyc[k] = -1; done_seen[k] = 1'b0;
        err_r1[k] = 0; err_r10[k] = 0;
      end
      repeat (3) @(negedge clk);
      for (int k = 0; k < NK; k++)
        chk(!cke_w[k] && !done_w[k] && !cs_w[k] && ras_w[k] && cas_w[k] && we_w[k],
            "R1", "reset state", {cke_w[k], done_w[k], cs_w[k], ras_w[k], cas_w[k], we_w[k]},
            6'b000111);
      rst_n = 1'b1;
      for (int t = 0; t < 3000 && !(done_seen[0] && done_seen[1]); t++) @(negedge clk);
      repeat (8) @(negedge clk);
      for (int k = 0; k < NK; k++) evaluate(k);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule